// File: doc/BRIEF.md
# Container Frame Disassembler

This block sits on the egress side of a frame-switched path and handles a single forwarding class. It takes in fixed-size container frames as a byte stream with an end-of-frame marker. Each frame holds packets packed back to back, and each packet piece is preceded by a small delineation header. The block reads those headers to locate packet boundaries. It strips the headers and any trailing padding, and joins a packet whose tail was carried over into the following frame.

Recovered bytes are written into a packet FIFO. The FIFO has three pointers: a write pointer, a commit pointer and a read pointer. The read side only releases bytes that lie below the commit pointer, so a packet leaves the block only once its final byte is stored. A partial packet can be thrown away cheaply by moving the write pointer back to the commit pointer. The output is a byte stream with an end-of-packet flag and a ready input for downstream flow control. The FIFO depth must be a power of two.

Top module: `cfd_frame_disassembler`

## Requirements
- R1: Every segment starts with a two-byte header. In the first byte, bit 7 is the first-piece flag, bit 6 is the last-piece flag, bits 5:4 are ignored, and bits 3:0 are length bits 11:8. The second byte carries length bits 7:0. Header bytes never appear on the output.
- R2: A header with length zero starts padding. Every remaining byte of that frame is discarded, whatever its value, and the next frame is parsed from its first byte as a header.
- R3: A segment that has both flags set is emitted as one packet, byte for byte in order, with `out_last` high on its final byte only.
- R4: A segment carrying the first flag without the last flag, which ends its frame, is joined with the continuation segment (last flag set, first flag clear) at the start of the next frame into one packet.
- R5: No byte of a packet reaches the output before the packet's final byte has been received.
- R6: A segment without the first flag that arrives while no partial packet is pending is discarded.
- R7: A segment with the first flag that arrives while a partial packet is pending discards the partial packet and starts a new one.
- R8: If a segment's length exceeds the free FIFO space, that segment and the rest of its frame are discarded and any pending partial packet is flushed. Packets completed earlier remain stored and are delivered.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold. `out_valid` is high only while the count of complete stored packets is nonzero.
- R10: In the cycle after reset is asserted, `out_valid` is low.
- R11: Several segments within one frame are processed back to back, and their packets are output in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_eof | input | 1 | Marks the final byte of a frame |
| out_ready | input | 1 | Downstream accepts a byte |
| out_valid | output | 1 | Packet byte present |
| out_data | output | 8 | Packet byte |
| out_last | output | 1 | Marks the final byte of a packet |

## Verification
Two things can occur on the same clock edge: a new packet is committed, which raises the complete-packet count, and the final byte of an older packet is handed downstream, which lowers the count. The bench provokes this with a frame containing a 4-byte packet followed directly by a 3-byte packet, with ready held high. Under that timing, the commit of the second packet lands on the same edge as the hand-off of the first packet's last byte. The result is judged on the output byte order and end flags, and by the property that `out_valid` never appears while the count is zero.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  // Segment header layout (first header byte)
  localparam int HDR_FIRST_BIT = 7;
  localparam int HDR_LAST_BIT  = 6;
  localparam int LEN_W         = 12;

  typedef enum logic [1:0] {
    ST_HDR0,
    ST_HDR1,
    ST_BODY,
    ST_SKIP
  } pst_t;
endpackage

// File: rtl/cfd_seg_parser.sv
module cfd_seg_parser
  import cfd_pkg::*;
#(
  parameter int PW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_eof,
  input  logic [PW-1:0] room_wr,
  input  logic [PW-1:0] room_cm,
  output logic          wr_en,
  output logic [7:0]    wr_byte,
  output logic          wr_eop,
  output logic          commit,
  output logic          rewind
);
  pst_t             st_q;
  logic             hf_q, hl_q;
  logic [3:0]       lhi_q;
  logic [LEN_W-1:0] remain_q;
  logic             seg_last_q, drop_q, pend_q;

  logic [LEN_W-1:0] seg_len;
  logic [PW-1:0]    room_sel;
  logic             too_big, body_end, hdr_take;

  always_comb begin
    seg_len  = {lhi_q, in_data};
    // a fresh packet may reclaim the pending partial's space
    room_sel = hf_q ? room_cm : room_wr;
    too_big  = 32'(seg_len) > 32'(room_sel);
    body_end = (remain_q == LEN_W'(1));
    wr_en    = in_valid && (st_q == ST_BODY) && !drop_q;
    wr_byte  = in_data;
    wr_eop   = body_end && seg_last_q;
    commit   = wr_en && body_end && seg_last_q;
    hdr_take = in_valid && (st_q == ST_HDR1) && !in_eof && (seg_len != '0);
    // R7 restart, R8 overflow flush
    rewind   = hdr_take && ((hf_q && pend_q) || ((hf_q || pend_q) && too_big));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_HDR0;
      hf_q       <= 1'b0;
      hl_q       <= 1'b0;
      lhi_q      <= '0;
      remain_q   <= '0;
      seg_last_q <= 1'b0;
      drop_q     <= 1'b0;
      pend_q     <= 1'b0;
    end else if (in_valid) begin
      unique case (st_q)
        ST_HDR0: begin
          hf_q  <= in_data[HDR_FIRST_BIT];
          hl_q  <= in_data[HDR_LAST_BIT];
          lhi_q <= in_data[3:0];
          st_q  <= ST_HDR1;
        end
        ST_HDR1: begin
          if (!in_eof) begin
            if (seg_len == '0) begin
              st_q <= ST_SKIP;                  // R2 padding
            end else if (!hf_q && !pend_q) begin
              drop_q     <= 1'b1;               // R6 orphan piece
              seg_last_q <= hl_q;
              remain_q   <= seg_len;
              st_q       <= ST_BODY;
            end else if (too_big) begin
              pend_q <= 1'b0;                   // R8 drop rest of frame
              st_q   <= ST_SKIP;
            end else begin
              pend_q     <= 1'b1;
              drop_q     <= 1'b0;
              seg_last_q <= hl_q;
              remain_q   <= seg_len;
              st_q       <= ST_BODY;
            end
          end
        end
        ST_BODY: begin
          remain_q <= remain_q - LEN_W'(1);
          if (body_end) st_q <= ST_HDR0;
          if (commit) pend_q <= 1'b0;
        end
        default: ;
      endcase
      if (in_eof) st_q <= ST_HDR0;
    end
  end
endmodule

// File: rtl/cfd_pkt_fifo.sv
module cfd_pkt_fifo #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_byte,
  input  logic          wr_eop,
  input  logic          commit,
  input  logic          rewind,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic [PW-1:0] room_wr,
  output logic [PW-1:0] room_cm,
  output logic [PW-1:0] pkt_cnt,
  output logic [PW-1:0] fill
);
  logic [8:0]    mem [DEPTH];
  logic [PW-1:0] wr_q, cm_q, rd_q;
  logic          rd_en, last_out;

  always_comb begin
    room_wr  = PW'(DEPTH) - (wr_q - rd_q);
    room_cm  = PW'(DEPTH) - (cm_q - rd_q);
    fill     = wr_q - rd_q;
    // only committed bytes may be read (R5)
    rd_en    = (cm_q != rd_q) && (!out_valid || out_ready);
    last_out = out_valid && out_ready && out_last;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q[AW-1:0]] <= {wr_eop, wr_byte};
  end

  always_ff @(posedge clk) begin
    if (rd_en) {out_last, out_data} <= mem[rd_q[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q      <= '0;
      cm_q      <= '0;
      rd_q      <= '0;
      out_valid <= 1'b0;
      pkt_cnt   <= '0;
    end else begin
      if (rewind)     wr_q <= cm_q;
      else if (wr_en) wr_q <= wr_q + PW'(1);
      if (commit) cm_q <= wr_q + PW'(1);
      if (rd_en)  rd_q <= rd_q + PW'(1);
      if (rd_en)          out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
      if (commit && !last_out)      pkt_cnt <= pkt_cnt + PW'(1);
      else if (!commit && last_out) pkt_cnt <= pkt_cnt - PW'(1);
    end
  end
endmodule

// File: rtl/cfd_frame_disassembler.sv
module cfd_frame_disassembler #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_eof,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last
);
  logic          wr_en, wr_eop, commit, rewind;
  logic [7:0]    wr_byte;
  logic [PW-1:0] room_wr, room_cm, pkt_cnt, fill;

  cfd_seg_parser #(.PW(PW)) parser_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_eof(in_eof),
    .room_wr(room_wr), .room_cm(room_cm),
    .wr_en(wr_en), .wr_byte(wr_byte), .wr_eop(wr_eop),
    .commit(commit), .rewind(rewind)
  );

  cfd_pkt_fifo #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) fifo_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_byte(wr_byte), .wr_eop(wr_eop),
    .commit(commit), .rewind(rewind),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last),
    .room_wr(room_wr), .room_cm(room_cm),
    .pkt_cnt(pkt_cnt), .fill(fill)
  );
endmodule

// File: rtl/cfd_checker.sv
module cfd_checker #(
  parameter int DEPTH = 1024,
  parameter int PW    = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          out_ready,
  input logic          out_valid,
  input logic [7:0]    out_data,
  input logic          out_last,
  input logic [PW-1:0] pkt_cnt,
  input logic [PW-1:0] fill
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R5 / R9: data only shows while a whole packet is stored
  assert_valid_needs_pkt_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> pkt_cnt != '0);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    32'(fill) <= DEPTH);

  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind cfd_frame_disassembler cfd_checker #(.DEPTH(DEPTH), .PW(PW)) chk_i (
  .clk(clk), .rst(rst), .out_ready(out_ready), .out_valid(out_valid),
  .out_data(out_data), .out_last(out_last), .pkt_cnt(pkt_cnt), .fill(fill)
);

// File: tb/cfd_frame_disassembler_tb.sv
module cfd_frame_disassembler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_eof = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic       out_valid, out_last;
  logic [7:0] out_data;

  int n_chk = 0, n_bad = 0;
  logic [7:0] fr[$];
  logic [8:0] expq[$];
  logic [8:0] rxq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfd_frame_disassembler #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_eof(in_eof), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last)
  );

  always @(negedge clk)
    if (!rst && out_valid && out_ready) rxq.push_back({out_last, out_data});

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic seg(input bit f, input bit l, input int n, input logic [7:0] b);
    fr.push_back({f, l, 2'b00, 4'(n >> 8)});
    fr.push_back(8'(n));
    for (int i = 0; i < n; i++) fr.push_back(8'(b + i));
  endtask

  task automatic pad(input int n, input logic [7:0] junk);
    fr.push_back(8'h00);
    fr.push_back(8'h00);
    for (int i = 2; i < n; i++) fr.push_back(junk);
  endtask

  task automatic exp_pkt(input int n, input logic [7:0] b);
    for (int i = 0; i < n; i++) expq.push_back({(i == n - 1), 8'(b + i)});
  endtask

  task automatic send_frame();
    for (int i = 0; i < fr.size(); i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_data  = fr[i];
      in_eof   = (i == fr.size() - 1);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_eof   = 1'b0;
    fr.delete();
  endtask

  task automatic drain_compare(input string req);
    int idle = 0;
    for (int c = 0; c < 600 && idle < 8; c++) begin
      @(negedge clk);
      if (out_valid) idle = 0; else idle++;
    end
    chk(rxq.size() == expq.size(), req, "byte count", rxq.size(), expq.size());
    for (int i = 0; i < expq.size() && i < rxq.size(); i++)
      chk(rxq[i] == expq[i], req, $sformatf("byte %0d {last,data}", i), rxq[i], expq[i]);
    rxq.delete();
    expq.delete();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
  endtask

  task automatic t_single();           // R1, R3
    seg(1, 1, 5, 8'h30); pad(4, 8'h41); exp_pkt(5, 8'h30);
    send_frame();
    drain_compare("R3");
  endtask

  task automatic t_multi_pad();        // R2, R11, commit meets hand-off
    seg(1, 1, 4, 8'h10); seg(1, 1, 3, 8'h20); pad(7, 8'hC5);
    exp_pkt(4, 8'h10); exp_pkt(3, 8'h20);
    send_frame();
    seg(1, 1, 2, 8'h28); exp_pkt(2, 8'h28);
    send_frame();
    drain_compare("R2 R11");
  endtask

  task automatic t_fragment();         // R4, R5
    seg(1, 0, 6, 8'h40);
    send_frame();
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R5", "out_valid with partial only", out_valid, 0);
    seg(0, 1, 3, 8'h46); exp_pkt(9, 8'h40);
    send_frame();
    drain_compare("R4");
  endtask

  task automatic t_orphan();           // R6
    seg(0, 1, 4, 8'h60); seg(1, 1, 2, 8'h70); exp_pkt(2, 8'h70);
    send_frame();
    drain_compare("R6");
  endtask

  task automatic t_restart();          // R7
    seg(1, 0, 3, 8'h80);
    send_frame();
    seg(1, 1, 2, 8'h90); exp_pkt(2, 8'h90);
    send_frame();
    drain_compare("R7");
  endtask

  task automatic t_backpressure();     // R9
    logic [7:0] d0;
    out_ready = 1'b0;
    seg(1, 1, 4, 8'hB0); exp_pkt(4, 8'hB0);
    send_frame();
    repeat (4) @(negedge clk);
    d0 = out_data;
    chk(out_valid == 1'b1, "R9", "out_valid while stalled", out_valid, 1);
    chk(d0 == 8'hB0, "R9", "first byte while stalled", d0, 8'hB0);
    repeat (3) @(negedge clk);
    chk(out_data == d0 && out_valid, "R9", "held byte", out_data, d0);
    @(posedge clk); #1; out_ready = 1'b1;
    drain_compare("R9");
  endtask

  task automatic t_overflow();         // R8
    out_ready = 1'b0;
    seg(1, 1, 40, 8'hA0); exp_pkt(40, 8'hA0);
    send_frame();
    seg(1, 0, 10, 8'h10);
    send_frame();
    seg(0, 1, 20, 8'h30); seg(1, 1, 2, 8'h50);
    send_frame();
    seg(0, 1, 3, 8'h58);
    send_frame();
    seg(1, 1, 5, 8'h60); exp_pkt(5, 8'h60);
    send_frame();
    @(posedge clk); #1; out_ready = 1'b1;
    drain_compare("R8");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_single();
    t_multi_pad();
    t_fragment();
    t_orphan();
    t_restart();
    t_backpressure();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule